// File: doc/BRIEF.md
# Bitwise Three-Input Lookup Unit

This datapath block evaluates an arbitrary boolean function of three inputs at every bit position of three 64-bit operands at once. An 8-bit truth-table value chooses the function. The three inputs at each position are one bit of the second source operand, one bit of the first source operand and one bit of the current destination value. The destination value is therefore both an input and the place the result is written. Any of the 256 functions of three variables comes out of the same hardware: three-way XOR, majority, AND, NOR or a plain pass-through of one operand.

The unit receives operand values that are already read from the register file, together with the table value and a record flag. It captures the result in a register one cycle later, qualified by a valid output. When the record flag is set, the unit also registers a three-bit sign summary of the result, treating it as a signed 64-bit number. The operand path is split into equal lanes. Each lane reports whether any of its result bits is set, and the zero detection is built from those lane reports.

Top module: `tri_lut_unit`

## Requirements
- R1: At each bit position i the index is {dest[i], src_a[i], src_b[i]}: the destination bit is index bit 2, the first source bit is index bit 1 and the second source bit is index bit 0. The result bit i is table[index].
- R2: Every one of the 64 bit positions is computed independently with the same table, so mixed operand patterns give a per-bit result with no interaction between positions.
- R3: out_valid equals in_valid of the previous cycle. Operations issued on consecutive cycles each produce their own result one cycle later, in order.
- R4: When in_valid is low, out_result and out_cond keep their previous values, whatever the other inputs do.
- R5: With in_record set, out_cond is {neg, pos, zero} in bits 2, 1 and 0, taken from the result as a signed 64-bit value. Exactly one of these bits is set.
- R6: With in_record clear, out_cond is 3'b000, even when the result is nonzero.
- R7: A synchronous active-high reset clears out_result and out_cond and deasserts out_valid.
- R8: Table value 8'h00 gives an all-zero result and 8'hFF an all-ones result, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request for this cycle |
| in_src_a | input | 64 | First source operand (index bit 1) |
| in_src_b | input | 64 | Second source operand (index bit 0) |
| in_dest | input | 64 | Current destination value (index bit 2) |
| in_table | input | 8 | Truth table, one bit per index |
| in_record | input | 1 | Request the sign summary |
| out_valid | output | 1 | Result is valid this cycle |
| out_result | output | 64 | Registered result |
| out_cond | output | 3 | {neg, pos, zero} summary, or zero when no summary was requested |

## Verification
The bench builds the unit with the default parameters: 64 data bits in eight lanes of 8 bits. With this setup the sign bit sits in the top lane and zero detection has to combine all eight lane reports, so a result that is nonzero in only one lane exercises that combining. Tables that pass a single operand straight through (8'hAA, 8'hCC, 8'hF0) show which operand feeds which index bit. The three-way XOR, majority and random tables cover mixed bit patterns.

// File: rtl/tri_lut_pkg.sv
package tri_lut_pkg;

    localparam int TABLE_W = 8;
    localparam int INDEX_W = 3;

    typedef logic [TABLE_W-1:0] table_t;
    typedef logic [INDEX_W-1:0] index_t;

    // Sign summary, most significant field first: neg, pos, zero.
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
    } cond_t;

    localparam cond_t COND_NONE = '{neg: 1'b0, pos: 1'b0, zero: 1'b0};

    // Destination is index bit 2, first source bit 1, second source bit 0.
    function automatic index_t make_index(logic dest_bit, logic first_bit, logic second_bit);
        return {dest_bit, first_bit, second_bit};
    endfunction

    function automatic logic table_pick(table_t tbl, index_t idx);
        return tbl[idx];
    endfunction

    function automatic cond_t summarize(logic sign_bit, logic any_set);
        cond_t c;
        c.neg  = sign_bit;
        c.zero = !any_set;
        c.pos  = any_set && !sign_bit;
        return c;
    endfunction

endpackage

// File: rtl/tri_lut_lane.sv
module tri_lut_lane
    import tri_lut_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  table_t            tbl,
    input  logic [LANE_W-1:0] first_src,
    input  logic [LANE_W-1:0] second_src,
    input  logic [LANE_W-1:0] dest_src,
    output logic [LANE_W-1:0] lane_res,
    output logic              lane_any
);

    for (genvar i = 0; i < LANE_W; i++) begin : g_bit
        index_t idx;
        assign idx         = make_index(dest_src[i], first_src[i], second_src[i]);
        assign lane_res[i] = table_pick(tbl, idx);
    end

    assign lane_any = |lane_res;

endmodule

// File: rtl/tri_lut_flags.sv
module tri_lut_flags
    import tri_lut_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] lane_any,
    input  logic             sign_bit,
    input  logic             record_en,
    output cond_t            cond
);

    logic any_set;
    assign any_set = |lane_any;

    always_comb begin
        if (record_en) cond = summarize(sign_bit, any_set);
        else           cond = COND_NONE;
    end

endmodule

// File: rtl/tri_lut_unit.sv
module tri_lut_unit
    import tri_lut_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src_a,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [DATA_W-1:0] in_dest,
    input  logic [7:0]        in_table,
    input  logic              in_record,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [2:0]        out_cond
);

    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] comb_res;
    logic [LANES-1:0]  lane_any;
    cond_t             comb_cond;
    cond_t             cond_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tri_lut_lane #(.LANE_W(LANE_W)) u_lane (
            .tbl        (in_table),
            .first_src  (in_src_a[g*LANE_W +: LANE_W]),
            .second_src (in_src_b[g*LANE_W +: LANE_W]),
            .dest_src   (in_dest[g*LANE_W +: LANE_W]),
            .lane_res   (comb_res[g*LANE_W +: LANE_W]),
            .lane_any   (lane_any[g])
        );
    end

    tri_lut_flags #(.LANES(LANES)) u_flags (
        .lane_any  (lane_any),
        .sign_bit  (comb_res[DATA_W-1]),
        .record_en (in_record),
        .cond      (comb_cond)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            cond_q     <= COND_NONE;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= comb_res;
                cond_q     <= comb_cond;
            end
        end
    end

    assign out_cond = cond_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R3
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_result) && $stable(out_cond))); // R4
    AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(out_cond)); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) (out_cond[0] |-> out_result == '0)); // R5
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst) (out_cond[2] |-> out_result[DATA_W-1])); // R5
    AST_RECORD_OFF: assert property (@(posedge clk) disable iff (rst) (in_valid && !in_record) |=> out_cond == 3'b000); // R6
    AST_TABLE_ONES: assert property (@(posedge clk) disable iff (rst) (in_valid && in_table == 8'hFF) |=> (&out_result)); // R8
    AST_TABLE_ZERO: assert property (@(posedge clk) disable iff (rst) (in_valid && in_table == 8'h00) |=> out_result == '0); // R8

endmodule

// File: tb/tri_lut_unit_bench.sv
module tri_lut_unit_bench;

    typedef struct packed {
        logic [7:0]  tbl;
        logic        rec;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] d;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 1'b1, 64'hFFFF_0000_1234_5678, 64'h0F0F_0F0F_0F0F_0F0F, 64'hDEAD_BEEF_0000_FFFF},
        '{8'hFF, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        '{8'h96, 1'b1, 64'h3333_3333_3333_3333, 64'h5555_5555_5555_5555, 64'h0F0F_0F0F_0F0F_0F0F},
        '{8'hE8, 1'b0, 64'h3333_3333_3333_3333, 64'h5555_5555_5555_5555, 64'h0F0F_0F0F_0F0F_0F0F},
        '{8'hCC, 1'b1, 64'h0000_0000_0000_00A5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{8'hAA, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0000},
        '{8'hF0, 1'b1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0000_0000_0000_0000},
        '{8'h80, 1'b1, 64'hFF00_FF00_FF00_FF00, 64'hF0F0_F0F0_F0F0_F0F0, 64'hCCCC_CCCC_CCCC_CCCC},
        '{8'h01, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_FFFF_0000_FFFF, 64'h00FF_00FF_00FF_00FF},
        '{8'h96, 1'b1, 64'h0000_0100_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        '{8'hE8, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000},
        '{8'hE8, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_src_a = '0;
    logic [63:0] in_src_b = '0;
    logic [63:0] in_dest = '0;
    logic [7:0]  in_table = '0;
    logic        in_record = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [2:0]  out_cond;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tri_lut_unit u_tri_lut_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dest(in_dest),
        .in_table(in_table), .in_record(in_record),
        .out_valid(out_valid), .out_result(out_result), .out_cond(out_cond)
    );

    function automatic logic [63:0] ref_lut(logic [7:0] tbl, logic [63:0] a, logic [63:0] b, logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = tbl[{d[i], a[i], b[i]}];
        return r;
    endfunction

    function automatic logic [2:0] ref_cond(logic rec, logic [63:0] r);
        if (!rec) return 3'b000;
        if ($signed(r) < 0) return 3'b100;
        if (r == 64'd0) return 3'b001;
        return 3'b010;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        in_valid  = 1'b1;
        in_table  = v.tbl;
        in_record = v.rec;
        in_src_a  = v.a;
        in_src_b  = v.b;
        in_dest   = v.d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] exp_r;
        logic [2:0]  exp_c;
        logic [63:0] held_r;
        logic [2:0]  held_c;
        vec_t        v;

        repeat (3) @(negedge clk);
        // R7: state while reset is held
        check("R7", {63'd0, out_valid}, 64'd0);
        check("R7", out_result, 64'd0);
        check("R7", {61'd0, out_cond}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // Vector table, issued back to back (R3)
        for (int i = 0; i <= NVEC; i++) begin
            if (i > 0) begin
                v     = VECS[i-1];
                exp_r = ref_lut(v.tbl, v.a, v.b, v.d);
                exp_c = ref_cond(v.rec, exp_r);
                check("R3", {63'd0, out_valid}, 64'd1);
                if (v.tbl == 8'h00 || v.tbl == 8'hFF) check("R8", out_result, exp_r);
                else                                  check("R1", out_result, exp_r);
                if (v.rec) check("R5", {61'd0, out_cond}, {61'd0, exp_c});
                else       check("R6", {61'd0, out_cond}, {61'd0, exp_c});
            end
            if (i < NVEC) drive(VECS[i]);
            else          in_valid = 1'b0;
            @(negedge clk);
        end
        check("R3", {63'd0, out_valid}, 64'd0);

        // Random tables and operands, all 64 positions (R2)
        for (int k = 0; k < 24; k++) begin
            v.tbl = 8'($urandom);
            v.rec = 1'($urandom);
            v.a   = {$urandom, $urandom};
            v.b   = {$urandom, $urandom};
            v.d   = {$urandom, $urandom};
            drive(v);
            @(negedge clk);
            in_valid = 1'b0;
            exp_r = ref_lut(v.tbl, v.a, v.b, v.d);
            exp_c = ref_cond(v.rec, exp_r);
            check("R2", out_result, exp_r);
            check(v.rec ? "R5" : "R6", {61'd0, out_cond}, {61'd0, exp_c});
        end

        // R4: idle inputs change but nothing is captured
        v = '{8'h96, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h2};
        drive(v);
        @(negedge clk);
        held_r = out_result;
        held_c = out_cond;
        in_valid  = 1'b0;
        in_table  = 8'hFF;
        in_record = 1'b0;
        in_src_a  = 64'hFFFF_0000_FFFF_0000;
        @(negedge clk);
        check("R4", out_result, held_r);
        check("R4", {61'd0, out_cond}, {61'd0, held_c});
        check("R4", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R4", out_result, held_r);

        // R7: reset after a nonzero result
        drive('{8'hFF, 1'b1, 64'h0, 64'h0, 64'h0});
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R7", out_result, 64'd0);
        check("R7", {61'd0, out_cond}, 64'd0);
        check("R7", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule